// File: doc/BRIEF.md
# Extended Capability List Walker

This engine searches the extended configuration space of a PCIe-style function for one capability and reports the result to the logic that asked for it. It reads the space one dword at a time through a simple read port. The port drives an address and a request, and waits for a valid strobe that carries 32 bits of data. The walk follows the linked list of capability headers. It begins at the fixed base offset 0x100 and moves from one header to the next through each header's next pointer.

Two kinds of request are supported, and a mode input selects between them.

- **Serial lookup:** finds the device serial number capability and returns the 64-bit number stored in that capability's body.
- **Vendor-specific lookup:** finds the first designated vendor-specific capability whose vendor ID and sub-ID both equal the keys given with the request, and returns its offset.

Every request ends with a one-cycle done pulse together with a found flag. A missing capability, an empty list, a broken link or a looping list all end the request with found low, so the engine never hangs. The caller may then go on without that capability.

Top module: `ecap_walker`

## Requirements
- R1: After reset, busy, done, found and rd_req are 0, and serial and cap_offset are 0.
- R2: The first header is read at offset 0x100. In a header, bits [15:0] are the capability ID and bits [31:20] are the next offset. Bits [21:20] of the next offset are forced to 0, so every read address is dword aligned.
- R3: When mode is 0, the engine finds the first capability with ID 0x0003. It then returns serial = {dword at offset+8, dword at offset+4} with found = 1.
- R4: When mode is 1, the engine finds the first capability with ID 0x0023 that meets two conditions: bits [15:0] of the dword at offset+4 equal vendor_key, and bits [15:0] of the dword at offset+8 equal dvsec_key. The upper bits of the dword at offset+8 are ignored. The engine returns that capability's offset on cap_offset with found = 1.
- R5: A capability with ID 0x0023 whose vendor or sub-ID does not match is skipped, and the walk continues along its next pointer.
- R6: A next offset below 0x100, including 0, ends the walk with found = 0.
- R7: If the first header is 0x00000000 or 0xFFFFFFFF, the list is treated as empty. The request ends with found = 0 after that single read.
- R8: A request reads at most MAX_STEPS headers (1024 by default). A list that loops ends with found = 0 after exactly MAX_STEPS header reads.
- R9: A start pulse while busy is ignored. The running request completes with its original mode and keys, and produces one done pulse only.
- R10: done is high for exactly one cycle per request, in the cycle after the last read completes. found, serial and cap_offset stay unchanged until the next accepted start.
- R11: While rd_req is high and rd_valid is low, rd_addr holds its value. An rd_valid that arrives while rd_req is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request pulse, accepted only when idle |
| mode | input | 1 | 0 = serial lookup, 1 = vendor-specific lookup |
| vendor_key | input | 16 | Vendor ID to match in vendor-specific mode |
| dvsec_key | input | 16 | Sub-ID to match in vendor-specific mode |
| rd_req | output | 1 | Read request to configuration space |
| rd_addr | output | 12 | Byte address of the dword being read |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Target capability located |
| serial | output | 64 | Serial number (serial mode) |
| cap_offset | output | 12 | Offset of the matching capability (vendor-specific mode) |

## Verification
The serial lookup runs on a list where the target sits second and the first link carries junk low bits. This separates correct masking and field extraction from an engine that only happens to land on the right dword.

The vendor-specific lookup runs on a chain of three capabilities with the same ID. One differs from the keys only in its sub-ID, another only in its vendor, and a third matches. This tells two-level matching apart from a match on the ID alone, and first-match order apart from last-match order.

Four list shapes should all end in not-found without a hang: an empty list of zeros, an empty list of ones, a link that points below the base, and a self-loop. For the self-loop, the count of header reads is checked against the step limit. A stray valid strobe and a second start during a walk show that neither disturbs a request.

// File: rtl/ecap_walker.sv
module ecap_walker #(
  parameter int unsigned MAX_STEPS = 1024,
  parameter logic [11:0] BASE_OFF  = 12'h100,
  parameter logic [15:0] SERIAL_ID = 16'h0003,
  parameter logic [15:0] VSPEC_ID  = 16'h0023
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mode,
  input  logic [15:0] vendor_key,
  input  logic [15:0] dvsec_key,
  output logic        rd_req,
  output logic [11:0] rd_addr,
  input  logic        rd_valid,
  input  logic [31:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic        found,
  output logic [63:0] serial,
  output logic [11:0] cap_offset
);
  localparam int unsigned STEP_W = $clog2(MAX_STEPS + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_VEND, S_SUB, S_SLO, S_SHI} st_t;

  st_t              st;
  logic [11:0]      ptr, link_q;
  logic [STEP_W-1:0] steps;
  logic             mode_q;
  logic [15:0]      vkey_q, dkey_q;
  logic [31:0]      lo_q;

  wire        hdr_blank = (rd_data == 32'h0) || (rd_data == 32'hFFFF_FFFF);
  wire [11:0] hdr_link  = {rd_data[31:22], 2'b00};
  wire [11:0] hop_to    = (st == S_HDR) ? hdr_link : link_q;
  wire [STEP_W-1:0] hops_done = (st == S_HDR) ? steps + 1'b1 : steps;
  wire        hop_ok    = (hop_to >= BASE_OFF) && (hops_done < STEP_W'(MAX_STEPS));

  assign busy   = (st != S_IDLE);
  assign rd_req = busy;

  always_comb begin
    case (st)
      S_VEND, S_SLO: rd_addr = ptr + 12'd4;
      S_SUB,  S_SHI: rd_addr = ptr + 12'd8;
      default:       rd_addr = ptr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ptr        <= '0;
      link_q     <= '0;
      steps      <= '0;
      mode_q     <= 1'b0;
      vkey_q     <= '0;
      dkey_q     <= '0;
      lo_q       <= '0;
      done       <= 1'b0;
      found      <= 1'b0;
      serial     <= '0;
      cap_offset <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q     <= mode;
          vkey_q     <= vendor_key;
          dkey_q     <= dvsec_key;
          ptr        <= BASE_OFF;
          steps      <= '0;
          found      <= 1'b0;
          serial     <= '0;
          cap_offset <= '0;
          st         <= S_HDR;
        end
        S_HDR: if (rd_valid) begin
          steps  <= steps + 1'b1;
          link_q <= hdr_link;
          if (steps == '0 && hdr_blank) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (!mode_q && rd_data[15:0] == SERIAL_ID) begin
            st <= S_SLO;
          end else if (mode_q && rd_data[15:0] == VSPEC_ID) begin
            st <= S_VEND;
          end else if (hop_ok) begin
            ptr <= hop_to;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_VEND: if (rd_valid) begin
          if (rd_data[15:0] == vkey_q) begin
            st <= S_SUB;
          end else if (hop_ok) begin
            ptr <= hop_to;
            st  <= S_HDR;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_SUB: if (rd_valid) begin
          if (rd_data[15:0] == dkey_q) begin
            found      <= 1'b1;
            cap_offset <= ptr;
            done       <= 1'b1;
            st         <= S_IDLE;
          end else if (hop_ok) begin
            ptr <= hop_to;
            st  <= S_HDR;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_SLO: if (rd_valid) begin
          lo_q <= rd_data;
          st   <= S_SHI;
        end
        S_SHI: if (rd_valid) begin
          serial <= {rd_data, lo_q};
          found  <= 1'b1;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FOUND_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> done); // R10
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R11
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00)); // R2
  AST_HDR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR) |-> (ptr >= BASE_OFF)); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    steps <= STEP_W'(MAX_STEPS)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mode_q) && $stable(vkey_q) && $stable(dkey_q))); // R9
endmodule

// File: tb/ecap_walker_tb.sv
module ecap_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] vendor_key = '0;
  logic [15:0] dvsec_key = '0;
  logic        rd_req;
  logic [11:0] rd_addr;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        busy, done, found;
  logic [63:0] serial;
  logic [11:0] cap_offset;

  int total = 0;
  int bad = 0;
  int reads = 0;
  int misaligned = 0;
  int addr_moved = 0;
  int done_cnt = 0;
  bit stray_req = 1'b0;
  logic [31:0] cfg [0:1023];

  always #5 clk = ~clk;

  ecap_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .vendor_key(vendor_key), .dvsec_key(dvsec_key),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .found(found), .serial(serial), .cap_offset(cap_offset)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        logic [11:0] a;
        a = rd_addr;
        if (a[1:0] != 2'b00) misaligned++;
        @(negedge clk);
        if (rd_addr !== a) addr_moved++;
        rd_valid = 1'b1;
        rd_data  = cfg[a[11:2]];
        reads++;
        @(negedge clk);
        rd_valid = 1'b0;
      end else if (stray_req) begin
        rd_valid = 1'b1;
        rd_data  = 32'h0000_0003;
        @(negedge clk);
        rd_valid = 1'b0;
        stray_req = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
  end

  task automatic clr();
    for (int i = 0; i < 1024; i++) cfg[i] = 32'h0;
  endtask

  task automatic put(input logic [11:0] a, input logic [31:0] d);
    cfg[a[11:2]] = d;
  endtask

  function automatic logic [31:0] hdr(input logic [11:0] nxt, input logic [15:0] id);
    return {nxt, 4'h1, id};
  endfunction

  task automatic pulse(input bit m, input logic [15:0] vk, input logic [15:0] dk);
    @(negedge clk);
    mode = m; vendor_key = vk; dvsec_key = dk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, {tag, " completion"}, 64'(done), 64'h1);
  endtask

  task automatic run(input bit m, input logic [15:0] vk, input logic [15:0] dk, input string tag);
    pulse(m, vk, dk);
    wait_done(tag);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !found && !rd_req, "R1 control outputs", {busy, done, found, rd_req}, 0);
    chk(serial == 0 && cap_offset == 0, "R1 data outputs", serial ^ 64'(cap_offset), 0);
  endtask

  task automatic t_serial();
    clr();
    put(12'h100, hdr(12'h143, 16'h0001));
    put(12'h140, hdr(12'h000, 16'h0003));
    put(12'h144, 32'h89AB_CDEF);
    put(12'h148, 32'h0123_4567);
    misaligned = 0;
    run(1'b0, 16'h0, 16'h0, "R3");
    chk(found, "R3 found", 64'(found), 1);
    chk(serial == 64'h0123_4567_89AB_CDEF, "R3 serial value", serial, 64'h0123_4567_89AB_CDEF);
    chk(misaligned == 0, "R2 link low bits masked", 64'(misaligned), 0);
    @(negedge clk);
    chk(!done, "R10 done one cycle", 64'(done), 0);
    repeat (10) @(negedge clk);
    chk(found && serial == 64'h0123_4567_89AB_CDEF, "R10 result held", serial, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic build_vspec();
    clr();
    put(12'h100, hdr(12'h180, 16'h0023));
    put(12'h104, 32'h0000_1E98);
    put(12'h108, 32'h0000_0002);
    put(12'h180, hdr(12'h200, 16'h0023));
    put(12'h184, 32'h0000_1AB4);
    put(12'h188, 32'h0000_0000);
    put(12'h200, hdr(12'h000, 16'h0023));
    put(12'h204, 32'h0000_1E98);
    put(12'h208, 32'hFFFF_0000);
  endtask

  task automatic t_vspec();
    build_vspec();
    run(1'b1, 16'h1E98, 16'h0000, "R4");
    chk(found && cap_offset == 12'h200, "R4/R5 skip mismatches, match at 0x200", 64'(cap_offset), 64'h200);
    run(1'b1, 16'h1E98, 16'h0002, "R4");
    chk(found && cap_offset == 12'h100, "R4 first match at 0x100", 64'(cap_offset), 64'h100);
    run(1'b1, 16'h1E98, 16'h0005, "R5");
    chk(!found, "R5 no key match ends at null link", 64'(found), 0);
    run(1'b0, 16'h0, 16'h0, "R6");
    chk(!found, "R6 serial absent not found", 64'(found), 0);
  endtask

  task automatic t_below();
    clr();
    put(12'h100, hdr(12'h080, 16'h0001));
    put(12'h080, hdr(12'h000, 16'h0003));
    reads = 0;
    run(1'b0, 16'h0, 16'h0, "R6");
    chk(!found && reads == 1, "R6 link below base stops", 64'(reads), 1);
  endtask

  task automatic t_empty();
    clr();
    reads = 0;
    run(1'b0, 16'h0, 16'h0, "R7");
    chk(!found && reads == 1, "R7 all-zero header empty", 64'(reads), 1);
    put(12'h100, 32'hFFFF_FFFF);
    reads = 0;
    run(1'b1, 16'hFFFF, 16'hFFFF, "R7");
    chk(!found && reads == 1, "R7 all-ones header empty", 64'(reads), 1);
  endtask

  task automatic t_loop();
    clr();
    put(12'h100, hdr(12'h100, 16'h0001));
    reads = 0;
    run(1'b0, 16'h0, 16'h0, "R8");
    chk(!found, "R8 loop not found", 64'(found), 0);
    chk(reads == 1024, "R8 header read count", 64'(reads), 1024);
  endtask

  task automatic t_busy_start();
    int d0;
    t_serial_list();
    d0 = done_cnt;
    pulse(1'b0, 16'h0, 16'h0);
    repeat (3) @(negedge clk);
    pulse(1'b1, 16'h1E98, 16'h0000);
    wait_done("R9");
    chk(found && serial == 64'h0123_4567_89AB_CDEF, "R9 original request kept", serial, 64'h0123_4567_89AB_CDEF);
    repeat (4) @(negedge clk);
    chk(!busy && done_cnt == d0 + 1, "R9 single done, no second walk", 64'(done_cnt - d0), 1);
  endtask

  task automatic t_serial_list();
    clr();
    put(12'h100, hdr(12'h000, 16'h0003));
    put(12'h104, 32'h89AB_CDEF);
    put(12'h108, 32'h0123_4567);
  endtask

  task automatic t_stray();
    int d0;
    d0 = done_cnt;
    @(negedge clk);
    stray_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && done_cnt == d0, "R11 stray valid ignored", 64'(busy), 0);
    chk(addr_moved == 0, "R11 address held while waiting", 64'(addr_moved), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_serial();
    t_vspec();
    t_below();
    t_empty();
    t_loop();
    t_busy_start();
    t_stray();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule